// File: doc/BRIEF.md
# Frame-Boundary Run/Stop Control Register Block

This block is the control and status slave of a streaming video processing core. Software uses a small word-addressed register bus to set a run flag and the output frame size in pixels and lines. The datapath starts each frame with a request. While the run flag is set and no frame is in progress, the block accepts that request. On acceptance it copies the run decision, the width and the height into one consistent set of settings and holds them for the whole frame.

Register writes never reach a frame that has already started. The datapath sees only the latched copies of width and height. A cleared run flag takes effect at the next frame-start request, which is then refused. The busy status follows the frame handshake and not the register write: it rises when a frame is accepted and falls only after the datapath reports that the frame is done.

Top module: `frame_gate_ctrl`

## Requirements
- R1: After reset the run flag reads 0, status reads 0, width reads DEF_W (640) and height reads DEF_H (480). `frm_busy` and `frm_ack` are 0, and `frm_width`/`frm_height` show the same defaults.
- R2: Word address 0 is the control register. Bit 0 is the run flag and is written from write-data bit 0. All other bits read as 0. Read data appears on `reg_rdata` on the clock edge that samples `reg_rd`.
- R3: Word address 3 holds the output width and word address 4 holds the output height. Each keeps the low DIM_W (12) bits of the written word, and the upper bits read as 0.
- R4: Word address 2 and every address above 4 read as 0 and ignore writes. Address 1 is the status register: bit 0 is the busy flag, the other bits read as 0, and writes have no effect on it.
- R5: While idle, a `frm_req` sampled with the run flag at 1 is accepted. From the next edge `frm_ack` is 1 for exactly one cycle and `frm_busy` is 1. A request sampled with the run flag at 0 is never acknowledged, and busy stays 0.
- R6: On acceptance, `frm_width` and `frm_height` take the register values as they stood before that edge. They hold those values until the next acceptance.
- R7: Width or height writes made during a frame leave `frm_width`/`frm_height` unchanged. The new values appear at the next accepted frame.
- R8: Clearing the run flag during a frame leaves busy (port and status bit) at 1 until `frm_done`. Busy falls on the edge that samples `frm_done`, and later requests are refused.
- R9: `frm_done` while idle has no effect. `frm_req` while busy is not acknowledged.
- R10: With the run flag still set, a request in the cycle after a completed frame is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| frm_req | input | 1 | Datapath asks to start a frame (held until acknowledged) |
| frm_done | input | 1 | Datapath reports the current frame finished |
| frm_ack | output | 1 | One-cycle frame acceptance pulse |
| frm_busy | output | 1 | Frame in progress |
| frm_width | output | DIM_W | Latched output width for the current frame |
| frm_height | output | DIM_W | Latched output height for the current frame |

## Verification
All results are due one edge after their stimulus. Read data arrives on the edge that samples `reg_rd`. Acknowledge, busy and the latched size change on the edge that samples an accepted request. Busy falls on the edge that samples `frm_done`. The bench drives every input on a falling edge and samples on the next falling edge, so exactly one rising edge lies between cause and check. The stability checks on the latched size and on busy therefore cover each cycle of a frame individually.

// File: rtl/frame_gate_pkg.sv
package frame_gate_pkg;
  localparam int OFS_CTRL   = 0;
  localparam int OFS_STAT   = 1;
  localparam int OFS_RSVD   = 2;
  localparam int OFS_WIDTH  = 3;
  localparam int OFS_HEIGHT = 4;
  localparam int NUM_OFS    = 5;
endpackage

// File: rtl/frame_gate_regbank.sv
module frame_gate_regbank
  import frame_gate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int DIM_W  = 12,
  parameter int DEF_W  = 640,
  parameter int DEF_H  = 480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy_i,
  output logic [DATA_W-1:0] rdata,
  output logic              go_o,
  output logic [DIM_W-1:0]  width_o,
  output logic [DIM_W-1:0]  height_o
);
  localparam int PAD_W = DATA_W - DIM_W;

  logic [NUM_OFS-1:0] sel;
  logic [DATA_W-1:0]  rd_mux;

  for (genvar i = 0; i < NUM_OFS; i++) begin : g_dec
    assign sel[i] = (addr == ADDR_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go_o     <= 1'b0;
      width_o  <= DIM_W'(DEF_W);
      height_o <= DIM_W'(DEF_H);
    end else if (wr) begin
      if (sel[OFS_CTRL])   go_o     <= wdata[0];
      if (sel[OFS_WIDTH])  width_o  <= wdata[DIM_W-1:0];
      if (sel[OFS_HEIGHT]) height_o <= wdata[DIM_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel[OFS_CTRL])   rd_mux[0] = go_o;
    if (sel[OFS_STAT])   rd_mux[0] = busy_i;
    if (sel[OFS_WIDTH])  rd_mux    = {{PAD_W{1'b0}}, width_o};
    if (sel[OFS_HEIGHT]) rd_mux    = {{PAD_W{1'b0}}, height_o};
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/frame_gate_seq.sv
module frame_gate_seq #(
  parameter int DIM_W = 12,
  parameter int DEF_W = 640,
  parameter int DEF_H = 480
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  input  logic             req_i,
  input  logic             done_i,
  output logic             ack_o,
  output logic             busy_o,
  output logic [DIM_W-1:0] width_o,
  output logic [DIM_W-1:0] height_o
);
  logic accept;
  assign accept = !busy_o && req_i && go_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o   <= 1'b0;
      ack_o    <= 1'b0;
      width_o  <= DIM_W'(DEF_W);
      height_o <= DIM_W'(DEF_H);
    end else begin
      ack_o <= accept;
      if (accept) begin
        busy_o   <= 1'b1;
        width_o  <= width_i;
        height_o <= height_i;
      end else if (busy_o && done_i) begin
        busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/frame_gate_ctrl.sv
module frame_gate_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int DIM_W  = 12,
  parameter int DEF_W  = 640,
  parameter int DEF_H  = 480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              frm_req,
  input  logic              frm_done,
  output logic              frm_ack,
  output logic              frm_busy,
  output logic [DIM_W-1:0]  frm_width,
  output logic [DIM_W-1:0]  frm_height
);
  logic             go_q;
  logic [DIM_W-1:0] width_q;
  logic [DIM_W-1:0] height_q;

  frame_gate_regbank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIM_W(DIM_W), .DEF_W(DEF_W), .DEF_H(DEF_H)
  ) u_regs (
    .clk(clk), .rst(rst), .rd(reg_rd), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .busy_i(frm_busy), .rdata(reg_rdata),
    .go_o(go_q), .width_o(width_q), .height_o(height_q)
  );

  frame_gate_seq #(
    .DIM_W(DIM_W), .DEF_W(DEF_W), .DEF_H(DEF_H)
  ) u_seq (
    .clk(clk), .rst(rst), .go_i(go_q), .width_i(width_q), .height_i(height_q),
    .req_i(frm_req), .done_i(frm_done), .ack_o(frm_ack), .busy_o(frm_busy),
    .width_o(frm_width), .height_o(frm_height)
  );
endmodule

// File: rtl/frame_gate_ctrl_chk.sv
module frame_gate_ctrl_chk #(
  parameter int DIM_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             go_q,
  input logic             frm_req,
  input logic             frm_done,
  input logic             frm_ack,
  input logic             frm_busy,
  input logic [DIM_W-1:0] frm_width,
  input logic [DIM_W-1:0] frm_height
);
  AST_ACK_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    frm_ack |-> frm_busy); // R5
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    frm_ack |=> !frm_ack); // R5
  AST_ACK_NEEDS_GO: assert property (@(posedge clk) disable iff (rst)
    frm_ack |-> $past(go_q && frm_req && !frm_busy)); // R5
  AST_SIZE_HELD: assert property (@(posedge clk) disable iff (rst)
    !frm_ack |-> ($stable(frm_width) && $stable(frm_height))); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (frm_busy && !frm_done) |=> frm_busy); // R8
  AST_BUSY_FALLS: assert property (@(posedge clk) disable iff (rst)
    (frm_busy && frm_done) |=> !frm_busy); // R8
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!frm_busy && !(frm_req && go_q)) |=> !frm_busy); // R9
endmodule

bind frame_gate_ctrl frame_gate_ctrl_chk #(.DIM_W(DIM_W)) u_chk (
  .clk(clk), .rst(rst), .go_q(go_q), .frm_req(frm_req), .frm_done(frm_done),
  .frm_ack(frm_ack), .frm_busy(frm_busy), .frm_width(frm_width),
  .frm_height(frm_height)
);

// File: tb/sim_frame_gate_ctrl.sv
`timescale 1ns/1ps
module sim_frame_gate_ctrl;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int DIM_W  = 12;
  localparam int NVEC   = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_rd = 1'b0, reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              frm_req = 1'b0, frm_done = 1'b0;
  logic              frm_ack, frm_busy;
  logic [DIM_W-1:0]  frm_width, frm_height;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  frame_gate_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIM_W(DIM_W)) u0 (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frm_req(frm_req),
    .frm_done(frm_done), .frm_ack(frm_ack), .frm_busy(frm_busy),
    .frm_width(frm_width), .frm_height(frm_height)
  );

  // {do_write, addr, wdata, expected readback}
  localparam logic [68:0] VECS [NVEC] = '{
    {1'b1, 4'd0, 32'hFFFF_FFFF, 32'h0000_0001},  // R2 only bit 0 kept
    {1'b1, 4'd0, 32'hFFFF_FFFE, 32'h0000_0000},  // R2 bit 0 clear
    {1'b1, 4'd3, 32'h0000_1320, 32'h0000_0320},  // R3 width truncated
    {1'b1, 4'd4, 32'hFFFF_F258, 32'h0000_0258},  // R3 height truncated
    {1'b1, 4'd2, 32'h0000_DEAD, 32'h0000_0000},  // R4 reserved
    {1'b1, 4'd1, 32'hFFFF_FFFF, 32'h0000_0000},  // R4 status not writable
    {1'b1, 4'd5, 32'h0000_0777, 32'h0000_0000},  // R4 beyond map
    {1'b1, 4'd15, 32'h0000_0111, 32'h0000_0000}, // R4 top address
    {1'b0, 4'd3, 32'h0000_0000, 32'h0000_0320},  // R4 width untouched
    {1'b0, 4'd4, 32'h0000_0000, 32'h0000_0258}   // R4 height untouched
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 busy", 32'(frm_busy), 32'd0);
    check("R1 ack", 32'(frm_ack), 32'd0);
    check("R1 frm_width", 32'(frm_width), 32'd640);
    check("R1 frm_height", 32'(frm_height), 32'd480);
    bus_read(4'd0, rv); check("R1 go", rv, 32'd0);
    bus_read(4'd1, rv); check("R1 status", rv, 32'd0);
    bus_read(4'd3, rv); check("R1 width", rv, 32'd640);
    bus_read(4'd4, rv); check("R1 height", rv, 32'd480);

    // Register vectors: R2, R3, R4
    for (int i = 0; i < NVEC; i++) begin
      logic [68:0] v;
      v = VECS[i];
      if (v[68]) bus_write(v[67:64], v[63:32]);
      bus_read(v[67:64], rv);
      if (v[67:64] == 4'd0)                          check("R2 ctrl readback", rv, v[31:0]);
      else if (v[68] && (v[67:64] inside {4'd3, 4'd4})) check("R3 size readback", rv, v[31:0]);
      else                                           check("R4 ignored/zero", rv, v[31:0]);
    end
    check("R4 status port", 32'(frm_busy), 32'd0);

    // R5 request with run flag clear is refused; R9 done while idle
    @(negedge clk); frm_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R5 no ack without go", 32'(frm_ack), 32'd0);
      check("R5 idle without go", 32'(frm_busy), 32'd0);
    end
    frm_req = 1'b0; frm_done = 1'b1;
    @(negedge clk); frm_done = 1'b0;
    check("R9 done while idle", 32'(frm_busy), 32'd0);

    // R5/R6 accepted frame
    bus_write(4'd0, 32'd1);
    frm_req = 1'b1;
    @(negedge clk);
    frm_req = 1'b0;
    check("R5 ack", 32'(frm_ack), 32'd1);
    check("R5 busy", 32'(frm_busy), 32'd1);
    check("R6 width latched", 32'(frm_width), 32'h320);
    check("R6 height latched", 32'(frm_height), 32'h258);
    @(negedge clk);
    check("R5 ack single cycle", 32'(frm_ack), 32'd0);
    bus_read(4'd1, rv); check("R4 status busy bit", rv, 32'd1);

    // R7 mid-frame size writes; R9 requests while busy
    bus_write(4'd3, 32'h400);
    bus_write(4'd4, 32'h300);
    check("R7 width held", 32'(frm_width), 32'h320);
    check("R7 height held", 32'(frm_height), 32'h258);
    frm_req = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check("R9 no ack while busy", 32'(frm_ack), 32'd0);
    end
    frm_req = 1'b0;

    // R8 run flag cleared mid-frame
    bus_write(4'd0, 32'd0);
    check("R8 busy after go cleared", 32'(frm_busy), 32'd1);
    bus_read(4'd1, rv); check("R8 status still 1", rv, 32'd1);
    frm_done = 1'b1;
    @(negedge clk); frm_done = 1'b0;
    check("R8 busy falls on done", 32'(frm_busy), 32'd0);
    bus_read(4'd1, rv); check("R8 status 0", rv, 32'd0);
    frm_req = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 refused after stop", 32'(frm_ack), 32'd0);
    check("R8 stays idle", 32'(frm_busy), 32'd0);
    frm_req = 1'b0;

    // R7 new size at next frame
    bus_write(4'd0, 32'd1);
    frm_req = 1'b1;
    @(negedge clk); frm_req = 1'b0;
    check("R7 next-frame ack", 32'(frm_ack), 32'd1);
    check("R7 new width", 32'(frm_width), 32'h400);
    check("R7 new height", 32'(frm_height), 32'h300);

    // R10 back-to-back frame
    bus_write(4'd3, 32'h0A0);
    frm_done = 1'b1;
    @(negedge clk); frm_done = 1'b0; frm_req = 1'b1;
    check("R10 idle after done", 32'(frm_busy), 32'd0);
    @(negedge clk); frm_req = 1'b0;
    check("R10 immediate ack", 32'(frm_ack), 32'd1);
    check("R10 busy again", 32'(frm_busy), 32'd1);
    check("R10 width", 32'(frm_width), 32'h0A0);
    check("R10 height", 32'(frm_height), 32'h300);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule